// File: doc/BRIEF.md
# Serial ADC Host Controller

This block sits in a system clock domain and runs one read of a 12-bit serial sampling converter for each accepted request. Each request carries the input selection (single-ended or differential, and which channel or polarity), a bit-order flag, and a variant select. The variant select says whether the converter expects a configuration word at all. The controller drives chip-select low and generates a serial clock divided down from the system clock. In command mode it shifts out a start bit followed by the three configuration bits. It then discards the converter's null bit and gathers the result most significant bit first.

When the bit-order flag is clear, the converter follows the result with its bits again in reverse order. The controller keeps the serial clock running for that tail, collects the reversed copy and reports whether it agrees with the first copy. When the flag is set, chip-select is released straight after the last result bit. The result is returned with a one-cycle valid pulse. A minimum chip-select high time separates transfers before a new request is taken.

The request side is a valid/ready pair: a request is taken in the cycle that both `req_valid` and `req_ready` are high, and the request fields are sampled only in that cycle. The result side has no back-pressure. `res_valid` pulses for one cycle and the consumer must take `res_data` and `res_mismatch` in that cycle.

Top module: `adc_host`

## Requirements
- R1: After reset, `adc_csn` is 1, `adc_sclk` is 0, `adc_mosi` is 0, `req_ready` is 1 and `res_valid` is 0.
- R2: `req_ready` is 1 only while no transfer is in progress or in its chip-select gap. A request is taken only when `req_valid` and `req_ready` are both 1, and `adc_csn` falls in the next cycle. `req_valid` asserted during a transfer, with any field values, changes nothing in that transfer.
- R3: `adc_sclk` is 0 whenever `adc_csn` is 1. Its first rise comes HALF_CYC system cycles after `adc_csn` falls. Each high phase and each low phase lasts HALF_CYC system cycles.
- R4: In command mode (`req_nocmd`=0), `adc_mosi` carries 1, `req_single`, `req_odd` and `req_msb_first`, one bit per serial clock pulse for pulses 1 to 4. The first bit is driven when chip-select falls, and each later bit changes only when `adc_sclk` falls. After these four bits, `adc_mosi` is 0.
- R5: In command mode, `adc_miso` is sampled on each `adc_sclk` rise. Rise 5 (the null bit) is discarded. Rises 6 to 17 give B11 down to B0, returned as `res_data[11]` down to `res_data[0]`.
- R6: In no-command mode (`req_nocmd`=1), `adc_mosi` stays 0. Rise 1 is ignored, rise 2 is the null bit, and rises 3 to 14 give B11 down to B0.
- R7: With `req_msb_first`=1, the transfer has exactly 17 pulses (command) or 14 pulses (no-command). `adc_csn` rises after the last pulse's low phase, which lasts HALF_CYC cycles.
- R8: With `req_msb_first`=0, 11 more pulses follow B0 and carry B1 up to B11. `res_mismatch` is 1 exactly when that copy differs from `res_data[11:1]`. With `req_msb_first`=1, `res_mismatch` is 0.
- R9: `res_valid` is a single-cycle pulse in the cycle `adc_csn` rises, and `res_mismatch` is 1 only alongside it.
- R10: After `adc_csn` rises, it stays high and `req_ready` stays 0 for CS_GAP cycles. `req_ready` returns in the cycle after that.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_single | input | 1 | 1 = single-ended input, 0 = differential |
| req_odd | input | 1 | Channel / polarity select |
| req_msb_first | input | 1 | 1 = result only; 0 = also read reversed copy |
| req_nocmd | input | 1 | 1 = converter takes no configuration word |
| adc_csn | output | 1 | Chip-select to converter, active low |
| adc_sclk | output | 1 | Divided serial clock |
| adc_mosi | output | 1 | Start bit and configuration to converter |
| adc_miso | input | 1 | Serial data from converter |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | RES_W | Conversion result, bit RES_W-1 is B11 |
| res_mismatch | output | 1 | Reversed copy disagreed with result |

## Verification
The assertions assume that the converter changes `adc_miso` only after a falling serial clock edge, so the value is steady whenever the controller raises the clock. They also assume that request fields matter only in the acceptance cycle. The bench drives requests one nanosecond after a rising system edge and holds them through acceptance. Its converter model updates `adc_miso` only on the negative system edge after it sees the serial clock fall, and it puts a deliberately wrong bit into the reversed copy when a mismatch is wanted. Requests asserted mid-transfer with flipped fields exercise the ignore rule without breaking those assumptions.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;
  localparam int CMD_W      = 3;  // input selection plus bit-order flag
  localparam int NULL_BITS  = 1;  // discarded bit before the result
  localparam int LEAD_NOCMD = 1;  // pulses before output enable, no-command variant

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_HIGH,
    ST_LOW,
    ST_GAP
  } xfer_st_t;
endpackage

// File: rtl/adc_host_timer.sv
module adc_host_timer #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (load)           cnt <= load_val;
    else if (cnt != '0)      cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  // the count never rises except on a load
  assert_tmr_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(load) && $past(rst_n)) |-> (cnt <= $past(cnt)));
endmodule

// File: rtl/adc_host_tx.sv
module adc_host_tx #(
  parameter int WW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [WW-1:0] word,
  input  logic          shift,
  output logic          mosi
);
  logic [WW-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sh <= '0;
    else if (load)   sh <= word;
    else if (shift)  sh <= {sh[WW-2:0], 1'b0};
  end

  assign mosi = sh[WW-1];

  // serial output moves only on a load or a shift
  assert_tx_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !shift) |=> $stable(mosi));
endmodule

// File: rtl/adc_host_rx.sv
module adc_host_rx #(
  parameter int RES_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             take_msb,
  input  logic             take_lsb,
  input  logic             bit_in,
  output logic [RES_W-1:0] word,
  output logic             mirror_bad
);
  logic [RES_W-2:0] mir;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word <= '0;
      mir  <= '0;
    end else if (clear) begin
      word <= '0;
      mir  <= '0;
    end else begin
      if (take_msb) word <= {word[RES_W-2:0], bit_in};
      if (take_lsb) mir  <= {bit_in, mir[RES_W-2:1]};
    end
  end

  // after the reversed tail, mir[0] holds B1 and mir[top] holds B11
  assign mirror_bad = (mir != word[RES_W-1:1]);

  assert_rx_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(take_msb && take_lsb));
endmodule

// File: rtl/adc_host.sv
module adc_host
  import adc_host_pkg::*;
#(
  parameter int RES_W    = 12,
  parameter int HALF_CYC = 2,
  parameter int CS_GAP   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_single,
  input  logic             req_odd,
  input  logic             req_msb_first,
  input  logic             req_nocmd,
  output logic             adc_csn,
  output logic             adc_sclk,
  output logic             adc_mosi,
  input  logic             adc_miso,
  output logic             res_valid,
  output logic [RES_W-1:0] res_data,
  output logic             res_mismatch
);
  localparam int FIRST_CMD = 1 + CMD_W + NULL_BITS + 1;
  localparam int FIRST_NC  = LEAD_NOCMD + NULL_BITS + 1;
  localparam int MAXP      = FIRST_CMD + 2 * RES_W;
  localparam int PW        = $clog2(MAXP + 1);
  localparam int TMAX      = (HALF_CYC > CS_GAP) ? HALF_CYC : CS_GAP;
  localparam int TW        = $clog2(TMAX + 1);
  localparam int WW        = CMD_W + 1;

  xfer_st_t        st;
  logic [PW-1:0]   pcnt, first_q, total_q, knext;
  logic [PW-1:0]   first_sel, total_sel;
  logic            msbf_q, csn_q, sclk_q, valid_q, mism_q;
  logic            accept, expired, done, rise_ev, fall_ev;
  logic            tload, take_msb, take_lsb, mirror_bad;
  logic [TW-1:0]   tval;
  logic [WW-1:0]   cmd_word;

  assign accept    = (st == ST_IDLE) && req_valid;
  assign knext     = pcnt + 1'b1;
  assign done      = (pcnt == total_q);
  assign rise_ev   = expired && ((st == ST_SETUP) || (st == ST_LOW && !done));
  assign fall_ev   = expired && (st == ST_HIGH);
  assign first_sel = req_nocmd ? PW'(FIRST_NC) : PW'(FIRST_CMD);
  assign total_sel = first_sel + PW'(RES_W - 1) + (req_msb_first ? '0 : PW'(RES_W - 1));
  assign cmd_word  = req_nocmd ? '0 : {1'b1, req_single, req_odd, req_msb_first};

  // timer reloads on acceptance and on every phase end
  assign tload = accept || (expired && (st == ST_SETUP || st == ST_HIGH || st == ST_LOW));
  assign tval  = (st == ST_LOW && done) ? TW'(CS_GAP - 1) : TW'(HALF_CYC - 1);

  // result capture windows by pulse number
  assign take_msb = rise_ev && (knext >= first_q) && (knext < first_q + PW'(RES_W));
  assign take_lsb = rise_ev && !msbf_q && (knext >= first_q + PW'(RES_W))
                    && (knext < first_q + PW'(2 * RES_W - 1));

  adc_host_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tload), .load_val(tval), .expired(expired)
  );

  adc_host_tx #(.WW(WW)) u_tx (
    .clk(clk), .rst_n(rst_n), .load(accept), .word(cmd_word),
    .shift(fall_ev), .mosi(adc_mosi)
  );

  adc_host_rx #(.RES_W(RES_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .clear(accept), .take_msb(take_msb),
    .take_lsb(take_lsb), .bit_in(adc_miso), .word(res_data),
    .mirror_bad(mirror_bad)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      pcnt    <= '0;
      first_q <= '0;
      total_q <= '0;
      msbf_q  <= 1'b1;
      csn_q   <= 1'b1;
      sclk_q  <= 1'b0;
      valid_q <= 1'b0;
      mism_q  <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      mism_q  <= 1'b0;
      unique case (st)
        ST_IDLE: if (req_valid) begin
          st      <= ST_SETUP;
          csn_q   <= 1'b0;
          pcnt    <= '0;
          first_q <= first_sel;
          total_q <= total_sel;
          msbf_q  <= req_msb_first;
        end
        ST_SETUP: if (expired) begin
          st     <= ST_HIGH;
          sclk_q <= 1'b1;
          pcnt   <= knext;
        end
        ST_HIGH: if (expired) begin
          st     <= ST_LOW;
          sclk_q <= 1'b0;
        end
        ST_LOW: if (expired) begin
          if (done) begin
            st      <= ST_GAP;
            csn_q   <= 1'b1;
            valid_q <= 1'b1;
            mism_q  <= !msbf_q && mirror_bad;
          end else begin
            st     <= ST_HIGH;
            sclk_q <= 1'b1;
            pcnt   <= knext;
          end
        end
        ST_GAP: if (expired) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign req_ready    = (st == ST_IDLE);
  assign adc_csn      = csn_q;
  assign adc_sclk     = sclk_q;
  assign res_valid    = valid_q;
  assign res_mismatch = mism_q;

  assert_sclk_parked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    adc_csn |-> !adc_sclk);

  assert_ready_only_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> adc_csn);

  assert_take_starts_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> $fell(adc_csn));

  assert_mosi_steady_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_sclk && $past(adc_sclk)) |-> $stable(adc_mosi));

  assert_valid_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  assert_valid_at_cs_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ($rose(adc_csn) && !req_ready));

  assert_mismatch_qual_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_mismatch |-> res_valid);

  assert_cs_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_csn) |=> (adc_csn && !adc_sclk));
endmodule

// File: tb/adc_host_tb.sv
module adc_host_tb;
  localparam int RES_W = 12;
  localparam int H     = 2;
  localparam int G     = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_single = 1'b0, req_odd = 1'b0;
  logic req_msb_first = 1'b1, req_nocmd = 1'b0;
  logic adc_miso = 1'b0;
  logic req_ready, adc_csn, adc_sclk, adc_mosi, res_valid, res_mismatch;
  logic [RES_W-1:0] res_data;

  always #4 clk = ~clk;

  adc_host #(.RES_W(RES_W), .HALF_CYC(H), .CS_GAP(G)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_single(req_single), .req_odd(req_odd), .req_msb_first(req_msb_first),
    .req_nocmd(req_nocmd), .adc_csn(adc_csn), .adc_sclk(adc_sclk),
    .adc_mosi(adc_mosi), .adc_miso(adc_miso), .res_valid(res_valid),
    .res_data(res_data), .res_mismatch(res_mismatch)
  );

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  // converter model contents for the current transfer
  logic [RES_W-1:0] s_word = '0;
  bit s_corrupt = 0;

  // reference model state
  bit m_busy = 0;
  int m_t = 0;
  bit m_single, m_odd, m_msbf, m_nocmd;
  int fc = 0;
  bit prev_sclk = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int first_rise(input bit nocmd);
    return nocmd ? 3 : 6;
  endfunction

  function automatic int n_pulses(input bit nocmd, input bit msbf);
    return first_rise(nocmd) + RES_W - 1 + (msbf ? 0 : RES_W - 1);
  endfunction

  // bit the converter presents for rising edge k
  function automatic logic slave_bit(input int k);
    int d;
    d = first_rise(m_nocmd);
    if (k < d - 1) return 1'b1;
    if (k == d - 1) return 1'b0;
    if (k < d + RES_W) return s_word[RES_W - 1 - (k - d)];
    if (!m_msbf && k < d + 2 * RES_W - 1)
      return s_word[k - d - RES_W + 1] ^ (s_corrupt && k == d + RES_W + 3);
    return 1'b0;
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_t = 0; fc = 0; prev_sclk = 0; adc_miso = 1'b0;
    end else begin
      int n, cs_end, e_sclk, e_mosi, e_csn, j;
      e_csn = 1; e_sclk = 0; e_mosi = 0;
      if (m_busy) begin
        n = n_pulses(m_nocmd, m_msbf);
        cs_end = 2 * H * n + H;
        e_csn = (m_t < cs_end) ? 0 : 1;
        if (m_t >= H && m_t < H + 2 * H * n && ((m_t - H) % (2 * H)) < H) e_sclk = 1;
        if (!m_nocmd) begin
          j = m_t / (2 * H);
          case (j)
            0: e_mosi = 1;
            1: e_mosi = m_single;
            2: e_mosi = m_odd;
            3: e_mosi = m_msbf;
            default: e_mosi = 0;
          endcase
        end
        chk("R7 csn", adc_csn, e_csn);
        chk("R3 sclk", adc_sclk, e_sclk);
        chk(m_nocmd ? "R6 mosi" : "R4 mosi", adc_mosi, e_mosi);
        chk("R10 ready", req_ready, 0);
        chk("R9 valid", res_valid, (m_t == cs_end) ? 1 : 0);
        if (m_t == cs_end) begin
          chk(m_nocmd ? "R6 data" : "R5 data", res_data, s_word);
          chk("R8 mismatch", res_mismatch, (s_corrupt && !m_msbf) ? 1 : 0);
        end else begin
          chk("R9 mismatch idle", res_mismatch, 0);
        end
      end else begin
        chk("R2 idle csn", adc_csn, 1);
        chk("R3 idle sclk", adc_sclk, 0);
        chk("R2 ready", req_ready, 1);
        chk("R9 idle valid", res_valid, 0);
      end

      // converter model: count falling serial clock edges in the frame
      if (adc_csn) fc = 0;
      else if (prev_sclk && !adc_sclk) fc++;
      prev_sclk = adc_sclk;

      // advance reference model
      if (m_busy) begin
        m_t++;
        if (m_t == 2 * H * n_pulses(m_nocmd, m_msbf) + H + G) m_busy = 0;
      end else if (req_valid) begin
        m_busy = 1; m_t = 0;
        m_single = req_single; m_odd = req_odd;
        m_msbf = req_msb_first; m_nocmd = req_nocmd;
      end
      adc_miso = m_busy ? slave_bit(fc + 1) : 1'b0;
    end
  end

  task automatic xfer(input bit sgl, input bit odd, input bit msbf, input bit nocmd,
                      input logic [RES_W-1:0] w, input bit corrupt);
    @(posedge clk); #1;
    while (!req_ready) begin @(posedge clk); #1; end
    s_word = w; s_corrupt = corrupt;
    req_single = sgl; req_odd = odd; req_msb_first = msbf; req_nocmd = nocmd;
    req_valid = 1'b1;
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state at the ports
    chk("R1 csn", adc_csn, 1);
    chk("R1 sclk", adc_sclk, 0);
    chk("R1 mosi", adc_mosi, 0);
    chk("R1 ready", req_ready, 1);
    chk("R1 valid", res_valid, 0);

    xfer(1, 0, 1, 0, 12'hA5C, 0);   // R5 R7 command, result only
    xfer(0, 1, 0, 0, 12'h3F1, 0);   // R8 reversed copy agrees
    xfer(1, 1, 0, 0, 12'h800, 1);   // R8 reversed copy corrupted
    xfer(0, 0, 1, 0, 12'h7FF, 1);   // R8 corruption ignored when result only
    xfer(1, 0, 1, 1, 12'h001, 0);   // R6 no-command, result only
    xfer(0, 1, 0, 1, 12'hFFF, 0);   // R6 R8 no-command with tail
    xfer(1, 0, 0, 1, 12'h555, 1);   // R6 R8 no-command corrupted tail

    // R2: request raised mid-transfer with flipped fields is ignored
    xfer(1, 0, 0, 0, 12'h9C3, 0);
    repeat (6) @(posedge clk);
    #1;
    req_single = 0; req_odd = 1; req_msb_first = 1; req_nocmd = 1;
    req_valid = 1'b1;
    repeat (8) @(posedge clk);
    #1 req_valid = 1'b0;

    // R10: back-to-back requests wait out the chip-select gap
    xfer(0, 0, 1, 0, 12'h0F0, 0);
    xfer(1, 1, 1, 0, 12'hC3A, 0);

    @(posedge clk); #1;
    while (!req_ready) begin @(posedge clk); #1; end
    repeat (10) @(posedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL R2 watchdog expired act=0 exp=1");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule